// File: doc/BRIEF.md
# Two-Wire Slave Byte Memory with Write Gate

This block is a slave on a two-wire serial bus. It holds a small byte memory that a bus master can read and write. A system clock oversamples the bus clock and data line, which arrive already synchronised. The block finds START and STOP conditions, bit edges and acknowledge slots from those samples. It drives the data line only through an open-drain pull-low output.

After START the slave takes in a device byte. The upper nibble of that byte must carry the device type code 1010b. The next three bits are ignored, and the last bit selects read (1) or write (0). In a write transaction, the first byte after the device byte sets the word pointer and each later byte is stored at that pointer. In a read transaction, bytes stream out from the pointer with an automatic increment. A separate level input decides whether written bytes reach the memory.

The slave takes part only while the mode-active input is high, which is after the surrounding logic has left its transmit-only phase. At all other times it lets the bus float.

Top module: `tws_slave`

## Requirements
- R1: After reset, and on every cycle that follows one with mode_act_i low, sda_pull_o is 0 and the slave gives no acknowledge to any bus traffic.
- R2: The slave pulls the data line low in the ninth bit time after a device byte whose bits [7:4] equal 1010b. For any other upper nibble it stays released for the device byte and for the rest of that transaction.
- R3: Device byte bits [3:1] are ignored: 0xAE, 0xAB and 0xA0 are all accepted.
- R4: In a write transaction (device byte bit 0 = 0), every received byte is acknowledged by a pull low in its ninth bit time.
- R5: The first byte after a write device byte loads the 7-bit word pointer from its bits [6:0]. Later bytes are stored at consecutive locations from that pointer.
- R6: A data byte is stored only if wr_en_i is high at the falling bus clock edge that ends its eighth bit. When wr_en_i is low the byte is still acknowledged and the pointer still advances, but the memory is unchanged.
- R7: A read transaction (device byte bit 0 = 1) sends bytes MSB first from the current pointer and increments the pointer after each byte. The pointer wraps from 127 to 0.
- R8: A master no-acknowledge (data line high in the ninth bit time) on a read byte makes the slave release the line and ignore further clocks until the next START.
- R9: A START received at any point, including mid-byte, restarts device byte reception with the bit count at zero.
- R10: A STOP returns the slave to idle with the line released. Bytes clocked after it without a new START are not acknowledged.
- R11: The slave samples the data line on rising bus clock edges. It changes its pull-low output only in response to a falling bus clock edge, so the output stays stable while the bus clock is high during data and acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data line (wired-AND level) |
| wr_en_i | input | 1 | Write gate: high lets written bytes reach memory |
| mode_act_i | input | 1 | High once transmit-only mode has ended; enables the slave |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |

## Verification
The assertions assume that scl_i stays at each level for at least two system clocks. They also assume that sda_i changes while scl_i is high only to form a START or a STOP, and that a master never issues START or STOP while the slave is pulling the line low. The bench master follows these rules. It holds each bus clock phase for several system clocks and moves its data line two clocks after the bus clock falls. It frames every condition with the bus clock high, and it samples the wired-AND line at the negative system clock edge so that it never samples on the edge where the slave's register updates.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tws_state_e;
endpackage

// File: rtl/tws_bus_cond.sv
module tws_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  // data moving while clock steadily high marks a condition
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          wr_en_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pull_o,
  output tws_state_e    state_o,
  output logic [CW-1:0] bit_cnt_o
);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);

  tws_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rx_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          rd_q, nack_q, pull_q;
  logic          byte_done;

  assign byte_done   = scl_fall_i && (cnt_q == LAST_BIT);
  assign mem_we_o    = active_i && (state_q == ST_WDATA) && byte_done && wr_en_i;
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = rx_q;
  assign pull_o      = pull_q;
  assign state_o     = state_q;
  assign bit_cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      nack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (!active_i) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise_i) begin
            rx_q  <= {rx_q[DW-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            unique case (state_q)
              ST_DEV: begin
                if (rx_q[DW-1 -: 4] == DEV_CODE) begin
                  rd_q    <= rx_q[0];
                  pull_q  <= 1'b1;
                  state_q <= ST_DEV_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_ADDR: begin
                ptr_q   <= rx_q[AW-1:0];
                pull_q  <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end
              default: begin
                ptr_q   <= ptr_q + 1'b1;
                pull_q  <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (state_q == ST_DEV_ACK && rd_q) begin
              pull_q  <= !mem_rdata_i[DW-1];
              tx_q    <= mem_rdata_i << 1;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RDATA;
            end else begin
              pull_q  <= 1'b0;
              state_q <= (state_q == ST_DEV_ACK) ? ST_ADDR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            pull_q  <= 1'b0;
            state_q <= ST_RACK;
          end else if (scl_fall_i) begin
            pull_q <= !tx_q[DW-1];
            tx_q   <= tx_q << 1;
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            nack_q <= sda_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_q <= ST_IDLE;
            end else begin
              cnt_q   <= '0;
              pull_q  <= !mem_rdata_i[DW-1];
              tx_q    <= mem_rdata_i << 1;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en_i,
  input  logic mode_act_i,
  output logic sda_pull_o
);
  logic          scl_rise, scl_fall, start, stop;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  tws_state_e    state_q;
  logic [CW-1:0] bit_cnt;

  tws_bus_cond i_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  tws_engine #(.DEPTH(DEPTH), .DW(DW)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (mode_act_i),
    .wr_en_i     (wr_en_i),
    .sda_i       (sda_i),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .pull_o      (sda_pull_o),
    .state_o     (state_q),
    .bit_cnt_o   (bit_cnt)
  );

  tws_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk
  import tws_pkg::*;
#(
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_i,
  input logic          mode_act_i,
  input logic          sda_pull_o,
  input tws_state_e    state_q,
  input logic [CW-1:0] bit_cnt
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_act_i |=> (!sda_pull_o && state_q == ST_IDLE));

  a_r8_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_pull_o);

  a_r9_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mode_act_i && $past(scl_i) && scl_i && $past(sda_i) && !sda_i)
    |=> (state_q == ST_DEV && bit_cnt == '0));

  a_r10_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(scl_i) && scl_i && !$past(sda_i) && sda_i)
    |=> (state_q == ST_IDLE && !sda_pull_o));

  a_r11_pull_on_low_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(sda_pull_o)) |-> !$past(scl_i));
endmodule

bind tws_slave tws_slave_chk #(.CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .mode_act_i (mode_act_i),
  .sda_pull_o (sda_pull_o),
  .state_q    (state_q),
  .bit_cnt    (bit_cnt)
);

// File: tb/test_tws_slave.sv
module test_tws_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wr_en = 1'b1, mode_act = 1'b0;
  logic sda_pull;
  logic sda_bus;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  string        exp_tag[$];
  logic [7:0]   exp_val[$];
  logic [7:0]   act_val[$];

  always #4 clk = !clk;

  assign sda_bus = m_sda & !sda_pull;

  tws_slave i_tws_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .wr_en_i    (wr_en),
    .mode_act_i (mode_act),
    .sda_pull_o (sda_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares produced results against the expected queue
  initial begin
    forever begin
      wait (act_val.size() > 0);
      begin
        logic [7:0] a, e;
        string t;
        a = act_val.pop_front();
        e = exp_val.pop_front();
        t = exp_tag.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(2);
    m_scl = 1'b1; tick(2);
    m_sda = 1'b0; tick(2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(2);
    m_scl = 1'b1; tick(2);
    m_sda = 1'b1; tick(4);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(2);
    m_scl = 1'b1; tick(4);
    m_scl = 1'b0; tick(2);
  endtask

  // send a byte; expected ack level (0 = pulled) goes to the scoreboard
  task automatic send_byte(input logic [7:0] b, input string tag, input logic exp_ack);
    logic a;
    exp_tag.push_back(tag);
    exp_val.push_back({7'd0, exp_ack});
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; tick(2);
    m_scl = 1'b1; tick(2);
    a = sda_bus;  tick(2);
    m_scl = 1'b0; tick(2);
    act_val.push_back({7'd0, a});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input string tag, input logic mack);
    logic [7:0] v;
    bit stable = 1'b1;
    exp_tag.push_back(tag);
    exp_val.push_back(exp);
    for (int i = 7; i >= 0; i--) begin
      logic s1, s2;
      m_sda = 1'b1; tick(2);
      m_scl = 1'b1; tick(1);
      s1 = sda_bus; tick(2);
      s2 = sda_bus; tick(1);
      m_scl = 1'b0; tick(2);
      v[i] = s1;
      if (s1 != s2) stable = 1'b0;
    end
    chk(stable, "R11 line stable while clock high", 0, 1);
    put_bit(mack);
    m_sda = 1'b1;
    act_val.push_back(v);
  endtask

  task automatic set_ptr(input logic [7:0] dev, input logic [7:0] addr, input string tag);
    bus_start();
    send_byte(dev, tag, 1'b0);
    send_byte(addr, tag, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    chk(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    rst_n = 1'b1;
    tick(3);

    // R1: inactive slave ignores a valid device byte
    bus_start();
    send_byte(8'hA0, "R1 inactive no ack", 1'b1);
    bus_stop();
    mode_act = 1'b1;
    tick(4);

    // R2 R4 R5: write three bytes from 0x10
    set_ptr(8'hA0, 8'h10, "R5 addr ack");
    send_byte(8'h11, "R4 data ack", 1'b0);
    send_byte(8'h22, "R4 data ack", 1'b0);
    send_byte(8'h33, "R4 data ack", 1'b0);
    bus_stop();

    // R3 R9 R7: don't-care bits, repeated START, sequential read
    set_ptr(8'hAE, 8'h10, "R3 dont care bits");
    bus_start();
    send_byte(8'hAB, "R9 repeated start ack", 1'b0);
    recv_byte(8'h11, "R7 read 0", 1'b0);
    recv_byte(8'h22, "R7 read 1", 1'b0);
    recv_byte(8'h33, "R7 read 2", 1'b1);
    bus_stop();

    // R2: wrong type code, rest of transaction ignored
    bus_start();
    send_byte(8'hB0, "R2 mismatch no ack", 1'b1);
    send_byte(8'h10, "R2 ignored after mismatch", 1'b1);
    bus_stop();

    // R6: gate low discards data but still acks
    wr_en = 1'b0;
    set_ptr(8'hA0, 8'h10, "R6 addr ack");
    send_byte(8'h99, "R6 gated ack", 1'b0);
    bus_stop();
    wr_en = 1'b1;
    set_ptr(8'hA0, 8'h10, "R6 addr ack");
    bus_start();
    send_byte(8'hA1, "R6 dev ack", 1'b0);
    recv_byte(8'h11, "R6 memory unchanged", 1'b1);
    bus_stop();

    // R7: pointer wrap 0x7F -> 0x00
    set_ptr(8'hA0, 8'h7E, "R7 addr ack");
    send_byte(8'hA5, "R7 data ack", 1'b0);
    send_byte(8'h5A, "R7 data ack", 1'b0);
    send_byte(8'h3C, "R7 data ack", 1'b0);
    bus_stop();
    set_ptr(8'hA0, 8'h7E, "R7 addr ack");
    bus_start();
    send_byte(8'hA1, "R7 dev ack", 1'b0);
    recv_byte(8'hA5, "R7 read 7E", 1'b0);
    recv_byte(8'h5A, "R7 read 7F", 1'b0);
    recv_byte(8'h3C, "R7 wrapped read 00", 1'b1);

    // R8: after NACK the line stays released
    recv_byte(8'hFF, "R8 released after nack", 1'b1);
    bus_stop();

    // R9: START mid-byte restarts device reception
    bus_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    send_byte(8'hA0, "R9 mid-byte restart ack", 1'b0);
    bus_stop();

    // R10: STOP mid-transfer, following byte without START ignored
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    m_scl = 1'b0; tick(2);
    send_byte(8'hA0, "R10 no ack after stop", 1'b1);
    bus_stop();

    // R1: dropping mode_act mid-read releases the line
    set_ptr(8'hA0, 8'h10, "R1 addr ack");
    bus_start();
    send_byte(8'hA1, "R1 dev ack", 1'b0);
    mode_act = 1'b0;
    tick(2);
    chk(sda_pull == 1'b0, "R1 released when inactive", sda_pull, 0);
    bus_stop();

    wait (act_val.size() == 0);
    tick(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule